// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Model

This block is a synthesizable model of a single-port synchronous SRAM whose write data pipeline is as long as its read data pipeline. Read and write commands can therefore follow each other on every clock with no idle cycle to turn the data bus around. All command pins are sampled on the rising clock edge. These pins are a clock enable, three chip selects, a write select, a load/continue select, one write strobe per byte lane and the address. A small on-chip counter walks the low two address bits through a four-beat burst in linear or interleaved order.

Two static inputs set the timing. `pipe_mode` high gives registered read data and writes that take their data two enabled edges after the command. `pipe_mode` low gives flow-through read data and writes that take their data one enabled edge after the command. The shared data bus is modelled as `d_in`, `d_out` and `d_oe`. A system bus wrapper drives the bus pins from `d_out` when `d_oe` is high. The block has no back-pressure and no valid/ready handshake. Every latency is fixed in enabled clock edges, and the only way to hold the pipeline is `clk_en_n`.

Top module: `lw_sram`

## Requirements
- R1: A load cycle (`burst_cont`=0, `clk_en_n`=0) selects the device only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Any other combination makes the cycle a deselect, which drives no read data and writes no memory.
- R2: On a load cycle, `addr` is captured and the command is a read when `wr_n`=1 and a write when `wr_n`=0. A continue cycle (`burst_cont`=1) repeats the last loaded command type at the next burst address and ignores the chip selects and `wr_n`. A continue that follows a deselect is itself a deselect.
- R3: With `pipe_mode`=1, read data for a command taken at enabled edge k is on `d_out` with `d_oe`=1 from enabled edge k+1 until the next enabled edge.
- R4: With `pipe_mode`=1, write data for a command taken at enabled edge k is sampled from `d_in` at enabled edge k+2.
- R5: With `pipe_mode`=0, read data is on `d_out` right after the command edge k and stays until the next enabled edge. Write data is sampled from `d_in` at enabled edge k+1.
- R6: Byte lane i occupies `d_in` bits [9i+8:9i] and is written only when `lane_wr_n[i]`=0 in the write's command cycle. A write with `lane_wr_n`=4'hF is an abort and changes no memory.
- R7: The burst counter changes only `addr[1:0]`. With `ilv_order`=0, the low bits of beat s are (loaded + s) mod 4. With `ilv_order`=1, they are loaded XOR s. After beat 3, the counter wraps back to the loaded value.
- R8: An edge with `clk_en_n`=1 changes no state. A read on the outputs keeps driving the same data, and a write data cycle keeps `d_oe` low.
- R9: `d_oe` is high only while read data is being presented and `out_en_n`=0. `out_en_n` acts combinationally and touches no state. During write data cycles and idle cycles `d_oe` is 0.
- R10: A read returns memory as left by every write command issued before it, including a write issued on the immediately preceding enabled edge in either mode.
- R11: After reset `d_oe` is 0, no command is pending, and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | 1 = registered read / two-edge write latency, 0 = flow-through / one-edge write latency |
| ilv_order | input | 1 | 1 = interleaved burst order, 0 = linear |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| burst_cont | input | 1 | 0 = load new address and command, 1 = continue burst |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| d_in | input | LANES*LANE_W | Write data from the bus |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| d_out | output | LANES*LANE_W | Read data toward the bus |
| d_oe | output | 1 | Drive enable for the bus |

## Verification
The assertions watch on every cycle the properties that need only the pins: output enable gating, frozen read data under a stalled clock, read data arriving at the right edge in both modes, and a quiet bus after deselects and flow-through writes. Data values are the bench's job. These include byte masking, write aborts, burst address order and wrap, and read-after-write coherence across back-to-back mixed commands. They appear only through directed and random command sequences compared against a reference memory kept in program order.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2
  } kind_e;

  // next burst low bits: linear adds the beat index, interleaved flips by it
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    return ilv ? (base ^ beat) : (base + beat);
  endfunction
endpackage

// File: rtl/lw_burst_addr.sv
module lw_burst_addr
  import lw_pkg::*;
(
  input  logic [1:0] base,
  input  logic [1:0] beat,
  input  logic       ilv,
  output logic [1:0] low
);
  assign low = burst_low(base, beat, ilv);
endmodule

// File: rtl/lw_cmd_ctrl.sv
module lw_cmd_ctrl
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ilv,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              burst_cont,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  output kind_e             s1_kind,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_mask
);
  localparam int HI_W = ADDR_W - 2;

  // burst tracking state
  kind_e           b_kind;
  logic [1:0]      b_base;
  logic [HI_W-1:0] b_hi;
  logic [1:0]      b_beat;

  logic            sel;
  logic [1:0]      nxt_beat;
  logic [1:0]      nxt_low;

  kind_e             c_kind;
  logic [ADDR_W-1:0] c_addr;
  logic [LANES-1:0]  c_mask;
  logic [1:0]        c_base;
  logic [HI_W-1:0]   c_hi;
  logic [1:0]        c_beat;

  assign sel      = !cs0_n && cs1 && !cs2_n;
  assign nxt_beat = b_beat + 2'd1;

  lw_burst_addr u_burst (
    .base (b_base),
    .beat (nxt_beat),
    .ilv  (ilv),
    .low  (nxt_low)
  );

  always_comb begin
    c_kind = K_IDLE;
    c_addr = addr;
    c_base = b_base;
    c_hi   = b_hi;
    c_beat = b_beat;
    if (!burst_cont) begin
      c_base = addr[1:0];
      c_hi   = addr[ADDR_W-1:2];
      c_beat = 2'd0;
      if (sel) c_kind = wr_n ? K_READ : K_WRITE;
    end else begin
      c_kind = b_kind;
      c_beat = nxt_beat;
      c_addr = {b_hi, nxt_low};
    end
    c_mask = (c_kind == K_WRITE) ? ~lane_wr_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_kind  <= K_IDLE;
      b_base  <= '0;
      b_hi    <= '0;
      b_beat  <= '0;
      s1_kind <= K_IDLE;
      s1_addr <= '0;
      s1_mask <= '0;
    end else if (en) begin
      b_kind  <= c_kind;
      b_base  <= c_base;
      b_hi    <= c_hi;
      b_beat  <= c_beat;
      s1_kind <= c_kind;
      s1_addr <= c_addr;
      s1_mask <= c_mask;
    end
  end
endmodule

// File: rtl/lw_store.sv
module lw_store
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    pipe,
  input  kind_e                   s1_kind,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  logic [LANES-1:0]        s1_mask,
  input  logic [LANES*LANE_W-1:0] d_in,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                    d_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  kind_e             s2_kind;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_mask;
  logic [DATA_W-1:0] q_reg;

  // write stage: second stage when pipelined, first when flow-through
  kind_e             w_kind;
  logic [ADDR_W-1:0] w_addr;
  logic [LANES-1:0]  w_mask;
  logic              w_go;
  logic [DATA_W-1:0] w_old;
  logic [DATA_W-1:0] w_word;
  logic [DATA_W-1:0] q_next;
  logic              rd_phase;

  assign w_kind = pipe ? s2_kind : s1_kind;
  assign w_addr = pipe ? s2_addr : s1_addr;
  assign w_mask = pipe ? s2_mask : s1_mask;
  assign w_go   = (w_kind == K_WRITE);
  assign w_old  = mem[w_addr];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign w_word[g*LANE_W +: LANE_W] =
      w_mask[g] ? d_in[g*LANE_W +: LANE_W] : w_old[g*LANE_W +: LANE_W];
  end

  // a write committing at the same edge as the read register load is forwarded
  assign q_next = (w_go && (w_addr == s1_addr)) ? w_word : mem[s1_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      s2_kind <= K_IDLE;
      s2_addr <= '0;
      s2_mask <= '0;
      q_reg   <= '0;
    end else if (en) begin
      if (w_go) mem[w_addr] <= w_word;
      s2_kind <= s1_kind;
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
      q_reg   <= q_next;
    end
  end

  assign rd_phase = pipe ? (s2_kind == K_READ) : (s1_kind == K_READ);
  assign d_out    = pipe ? q_reg : mem[s1_addr];
  assign d_oe     = rd_phase && !out_en_n;
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    ilv_order,
  input  logic                    clk_en_n,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic                    cs2_n,
  input  logic                    burst_cont,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] d_in,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                    d_oe
);
  logic              en;
  kind_e             s1_kind;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;

  assign en = !clk_en_n;

  lw_cmd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .ilv        (ilv_order),
    .cs0_n      (cs0_n),
    .cs1        (cs1),
    .cs2_n      (cs2_n),
    .burst_cont (burst_cont),
    .wr_n       (wr_n),
    .lane_wr_n  (lane_wr_n),
    .addr       (addr),
    .s1_kind    (s1_kind),
    .s1_addr    (s1_addr),
    .s1_mask    (s1_mask)
  );

  lw_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pipe     (pipe_mode),
    .s1_kind  (s1_kind),
    .s1_addr  (s1_addr),
    .s1_mask  (s1_mask),
    .d_in     (d_in),
    .out_en_n (out_en_n),
    .d_out    (d_out),
    .d_oe     (d_oe)
  );
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              clk_en_n,
  input logic              cs0_n,
  input logic              cs1,
  input logic              cs2_n,
  input logic              burst_cont,
  input logic              wr_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] d_out,
  input logic              d_oe
);
  logic sel;
  assign sel = !cs0_n && cs1 && !cs2_n;

  // R9: output enable high always releases the bus
  a_r9_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !d_oe);

  // R8: a stalled edge leaves the read data untouched
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(d_out));

  // R5: flow-through read drives right after its command edge
  a_r5_ft_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !clk_en_n && !burst_cont && sel && wr_n) |=> (d_oe || out_en_n));

  // R3: pipelined read drives after the following enabled edge
  a_r3_pipe_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !clk_en_n && !burst_cont && sel && wr_n) ##1 !clk_en_n
      |=> (d_oe || out_en_n));

  // R1: flow-through deselect leaves the bus released
  a_r1_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !clk_en_n && !burst_cont && !sel) |=> !d_oe);

  // R9: flow-through write data cycle keeps the bus released
  a_r9_ft_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !clk_en_n && !burst_cont && sel && !wr_n) |=> !d_oe);
endmodule

bind lw_sram lw_sram_chk #(.DATA_W(LANES*LANE_W)) u_lw_sram_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pipe_mode  (pipe_mode),
  .clk_en_n   (clk_en_n),
  .cs0_n      (cs0_n),
  .cs1        (cs1),
  .cs2_n      (cs2_n),
  .burst_cont (burst_cont),
  .wr_n       (wr_n),
  .out_en_n   (out_en_n),
  .d_out      (d_out),
  .d_oe       (d_oe)
);

// File: tb/test_lw_sram.sv
`timescale 1ns/1ps
module test_lw_sram;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe_mode = 1'b0;
  logic          ilv_order = 1'b0;
  logic          clk_en_n = 1'b0;
  logic          cs0_n = 1'b1;
  logic          cs1 = 1'b1;
  logic          cs2_n = 1'b0;
  logic          burst_cont = 1'b0;
  logic          wr_n = 1'b1;
  logic [LN-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] d_out;
  logic          d_oe;

  always #2.5 clk = ~clk;

  lw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_lw_sram (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ilv_order(ilv_order),
    .clk_en_n(clk_en_n), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .burst_cont(burst_cont), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .d_in(d_in), .out_en_n(out_en_n), .d_out(d_out), .d_oe(d_oe)
  );

  // reference model state (kind: 0 idle, 1 read, 2 write)
  logic [DW-1:0] ref_mem [1<<AW];
  int            bk, exp_k, prev_k;
  logic [1:0]    bbase, bbeat;
  logic [AW-3:0] bhi;
  logic [DW-1:0] exp_d, prev_d, need1, need2;
  int            checks = 0, fails = 0;
  string         tag = "R11 reset";
  bit            done = 0;

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom} & {DW{1'b1}};
  endfunction

  function automatic logic [1:0] beat_low(input logic [1:0] b, input logic [1:0] s,
                                          input logic il);
    return il ? (b ^ s) : (b + s);
  endfunction

  task automatic check_out();
    checks++;
    if (!out_en_n && exp_k == 1) begin
      if (d_oe !== 1'b1 || d_out !== exp_d) begin
        fails++;
        $display("FAIL %s: d_oe=%0b d_out=%h expected d_oe=1 d_out=%h", tag, d_oe, d_out, exp_d);
      end
    end else if (d_oe !== 1'b0) begin
      fails++;
      $display("FAIL %s: d_oe=%0b expected d_oe=0", tag, d_oe);
    end
  endtask

  task automatic model_edge();
    int k;
    logic [AW-1:0] a2;
    logic [DW-1:0] wd, rd, n1, n2;
    if (!burst_cont) begin
      k = (!cs0_n && cs1 && !cs2_n) ? (wr_n ? 1 : 2) : 0;
      bbase = addr[1:0]; bhi = addr[AW-1:2]; bbeat = 2'd0; bk = k; a2 = addr;
    end else begin
      k = bk; bbeat = bbeat + 2'd1;
      a2 = {bhi, beat_low(bbase, bbeat, ilv_order)};
    end
    wd = rnd_word();
    if (k == 2)
      for (int i = 0; i < LN; i++)
        if (!lane_wr_n[i]) ref_mem[a2][i*LW +: LW] = wd[i*LW +: LW];
    rd = ref_mem[a2];
    n1 = need2; n2 = rnd_word();
    if (k == 2) begin
      if (pipe_mode) n2 = wd; else n1 = wd;
    end
    need1 = n1; need2 = n2;
    if (pipe_mode) begin
      exp_k = prev_k; exp_d = prev_d; prev_k = k; prev_d = rd;
    end else begin
      exp_k = k; exp_d = rd;
    end
  endtask

  // one clock: check outputs, drive inputs, take the edge, update model
  task automatic cyc(input bit stall, input bit c0n, input bit c1, input bit c2n,
                     input bit wrn, input bit cont, input logic [LN-1:0] lanes,
                     input logic [AW-1:0] ad, input bit oen);
    check_out();
    clk_en_n = stall; cs0_n = c0n; cs1 = c1; cs2_n = c2n; wr_n = wrn;
    burst_cont = cont; lane_wr_n = lanes; addr = ad; out_en_n = oen; d_in = need1;
    @(posedge clk);
    if (!stall) model_edge();
    @(negedge clk);
  endtask

  task automatic rd_load(input logic [AW-1:0] ad); cyc(0,0,1,0,1,0,'1,ad,0); endtask
  task automatic wr_load(input logic [AW-1:0] ad, input logic [LN-1:0] l); cyc(0,0,1,0,0,0,l,ad,0); endtask
  task automatic cont_c(input logic [LN-1:0] l); cyc(0,1,0,1,1,1,l,'0,0); endtask
  task automatic idle(); cyc(0,1,1,0,1,0,'1,'0,0); endtask
  task automatic stall_c(); cyc(1,0,1,0,0,0,'0,6'h3F,0); endtask

  task automatic do_reset(input bit p, input bit il);
    @(negedge clk);
    rst_n = 1'b0; pipe_mode = p; ilv_order = il;
    clk_en_n = 0; cs0_n = 1; burst_cont = 0; out_en_n = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    bk = 0; exp_k = 0; prev_k = 0; exp_d = '0; prev_d = '0; bbase = 0; bbeat = 0; bhi = 0;
    need1 = rnd_word(); need2 = rnd_word();
    rst_n = 1'b1;
  endtask

  task automatic run_mode(input bit p, input bit il);
    do_reset(p, il);
    tag = "R11 reset idle";
    idle(); idle();
    rd_load(6'h05); rd_load(6'h22); idle(); idle();
    tag = p ? "R4 R7 R2 burst write" : "R5 R7 R2 burst write";
    wr_load(6'h0A, 4'h0); cont_c(4'h0); cont_c(4'h0); cont_c(4'h0);
    tag = p ? "R3 R7 burst read with wrap" : "R5 R7 burst read with wrap";
    rd_load(6'h0A); cont_c('1); cont_c('1); cont_c('1); cont_c('1);
    rd_load(6'h08); rd_load(6'h09); rd_load(6'h0B);
    tag = "R6 R10 masked write then read";
    wr_load(6'h0A, 4'b1010); rd_load(6'h0A); wr_load(6'h0B, 4'b0110);
    rd_load(6'h0B); rd_load(6'h0A); wr_load(6'h0A, 4'b0000); rd_load(6'h0A);
    tag = "R6 write abort";
    wr_load(6'h0B, 4'hF); rd_load(6'h0B); idle();
    tag = "R1 R2 deselect and continue";
    cyc(0,0,0,0,1,0,'1,6'h0A,0); cont_c('1); cont_c('1);
    cyc(0,0,1,1,0,0,4'h0,6'h0A,0); cont_c(4'h0); rd_load(6'h0A); idle(); idle();
    tag = "R8 stall";
    rd_load(6'h0B); stall_c(); stall_c(); cont_c('1); stall_c(); cont_c('1);
    wr_load(6'h2C, 4'h0); stall_c(); stall_c(); rd_load(6'h2C); stall_c(); idle(); idle();
    tag = "R9 output enable";
    rd_load(6'h0A); cyc(0,1,0,1,1,1,'1,'0,1); cyc(0,1,0,1,1,1,'1,'0,0);
    wr_load(6'h0A, 4'h0); cyc(0,1,1,0,1,0,'1,'0,0); rd_load(6'h0A); idle(); idle();
    tag = "R10 random mix";
    for (int n = 0; n < 500; n++) begin
      cyc(($urandom % 10) == 0, ($urandom % 10) == 0, ($urandom % 12) != 0,
          ($urandom % 12) == 0, $urandom % 2, ($urandom % 3) == 0,
          ($urandom % 6 == 0) ? 4'hF : 4'($urandom), AW'($urandom),
          ($urandom % 10) == 0);
    end
    idle(); idle(); idle();
  endtask

  initial begin
    void'($urandom(32'd2024));
    run_mode(1'b1, 1'b0);
    run_mode(1'b1, 1'b1);
    run_mode(1'b0, 1'b0);
    run_mode(1'b0, 1'b1);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule